// File: doc/BRIEF.md
# Packet-to-Cache-Block DMA Segmenter

This block accepts one packet at a time from a DMA channel and sends it to an external accelerator as a series of 32-byte write blocks. The first doubleword of the packet's descriptor goes ahead of the payload, in the lowest 8 bytes of the first block, so the accelerator knows where to write its results. Payload bytes follow it in little-endian order. Each block's write address tells the receiver three things: the block's position in the packet, the source channel, and, on the final block, how many of its bytes are valid.

A packet starts with a handshake that carries the channel, the payload length in bytes (1 or more) and the descriptor word. The payload then arrives as 64-bit words on a valid/ready stream. Once the final block has been accepted, the block asks for a descriptor status writeback that carries the packet length. When that writeback is acknowledged, it pulses a completion interrupt and becomes ready for the next packet.

Top module: `pkt_blk_segmenter`

## Requirements
- R1: A packet of L payload bytes is sent as exactly ceil((L+8)/32) blocks, each carrying a full 256-bit data word.
- R2: Bytes 0..7 of the first block hold the descriptor word. Payload byte k sits at stream byte 8+k, which is byte (8+k) mod 32 of block (8+k)/32.
- R3: Block address = cfg_base + channel×2^18 + position×2^16, plus valid×2^11 on the end block only.
- R4: Position code is 0 on the first block of a multi-block packet, 1 on every block between the first and the last, and 2 on the last block. Code 3 never appears.
- R5: The valid field on the end block is L+8−32×(blocks−1), taken mod 32, so a full final block encodes 0.
- R6: A packet with L+8 ≤ 32 is sent as a single block with position code 2 and its valid count.
- R7: In the final block, every byte lane at or above the valid count is zero, whatever the payload stream carried there.
- R8: While blk_valid is high and blk_ready is low, blk_valid, blk_addr and blk_data hold steady.
- R9: wb_req rises only after the last block has been accepted. It carries wb_len = L and stays high until wb_ack.
- R10: irq is a single-cycle pulse in the cycle after wb_req and wb_ack are both high. It does not occur otherwise.
- R11: pkt_ready is high only while idle. A start request presented during a packet has no effect on that packet's blocks or writeback.
- R12: After reset, pkt_ready is high and blk_valid, pay_ready, wb_req and irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | ADDR_W | Base address of the accelerator window |
| pkt_valid | input | 1 | Start request for a packet |
| pkt_ready | output | 1 | Block idle, start request accepted |
| pkt_chan | input | CH_W | Source channel number |
| pkt_len | input | LEN_W | Payload length in bytes (≥ 1) |
| pkt_dscr | input | 64 | First descriptor doubleword |
| pay_valid | input | 1 | Payload word valid |
| pay_ready | output | 1 | Payload word taken |
| pay_data | input | 64 | Payload word, byte 0 in bits 7:0 |
| blk_valid | output | 1 | Block write valid |
| blk_ready | input | 1 | Block write accepted |
| blk_addr | output | ADDR_W | Block write address |
| blk_data | output | 256 | Block write data, byte 0 in bits 7:0 |
| wb_req | output | 1 | Descriptor status writeback request |
| wb_ack | input | 1 | Writeback done |
| wb_len | output | LEN_W | Length reported in the writeback |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The assertions assume that pkt_len is at least 1. They also assume that the payload stream delivers exactly ceil(L/8) words per packet and that cfg_base does not change while a packet is in flight. The bench starts each packet with a nonzero length and feeds exactly the word count the length implies. It fills the unused tail bytes of the last payload word with a nonzero filler, and it holds cfg_base constant. Payload gaps and output backpressure vary with the packet length, so the hold-steady and writeback-ordering properties are exercised under both stalled and free-flowing conditions.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int BLK_BYTES  = 32;
  localparam int DW_BYTES   = 8;
  localparam int SLOTS      = BLK_BYTES / DW_BYTES;
  localparam int BLK_BITS   = BLK_BYTES * 8;
  localparam int CH_SHIFT   = 18;
  localparam int POS_SHIFT  = 16;
  localparam int VAL_SHIFT  = 11;

  localparam logic [1:0] POS_SOP = 2'd0;
  localparam logic [1:0] POS_MOP = 2'd1;
  localparam logic [1:0] POS_EOP = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_FILL, S_SEND, S_WB, S_IRQ} seg_state_e;

  // number of blocks needed for descriptor word plus payload
  function automatic logic [31:0] blocks_for(input logic [31:0] len);
    return (len + 32'(DW_BYTES) + 32'(BLK_BYTES - 1)) / 32'(BLK_BYTES);
  endfunction

  // valid bytes in the final block, 1..32
  function automatic logic [31:0] last_valid(input logic [31:0] len);
    return len + 32'(DW_BYTES) - (blocks_for(len) - 32'd1) * 32'(BLK_BYTES);
  endfunction

  // payload words to pull from the stream
  function automatic logic [31:0] words_for(input logic [31:0] len);
    return (len + 32'(DW_BYTES - 1)) / 32'(DW_BYTES);
  endfunction
endpackage

// File: rtl/seg_addr.sv
module seg_addr import seg_pkg::*; #(
  parameter int ADDR_W = 40,
  parameter int CH_W   = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [CH_W-1:0]   chan,
  input  logic [1:0]        pos,
  input  logic [4:0]        vfield,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] ch_term, pos_term, val_term;

  always_comb begin
    ch_term  = ADDR_W'(chan) << CH_SHIFT;
    pos_term = ADDR_W'(pos) << POS_SHIFT;
    val_term = (pos == POS_EOP) ? (ADDR_W'(vfield) << VAL_SHIFT) : '0;
    addr     = base + ch_term + pos_term + val_term;
  end
endmodule

// File: rtl/seg_mask.sv
module seg_mask import seg_pkg::*; (
  input  logic                trim,
  input  logic [5:0]          keep,
  input  logic [BLK_BITS-1:0] din,
  output logic [BLK_BITS-1:0] dout
);
  for (genvar g = 0; g < BLK_BYTES; g++) begin : g_lane
    assign dout[8*g +: 8] = (!trim || (6'(g) < keep)) ? din[8*g +: 8] : 8'h00;
  end
endmodule

// File: rtl/pkt_blk_segmenter.sv
module pkt_blk_segmenter import seg_pkg::*; #(
  parameter int ADDR_W = 40,
  parameter int CH_W   = 2,
  parameter int LEN_W  = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   cfg_base,
  input  logic                pkt_valid,
  output logic                pkt_ready,
  input  logic [CH_W-1:0]     pkt_chan,
  input  logic [LEN_W-1:0]    pkt_len,
  input  logic [63:0]         pkt_dscr,
  input  logic                pay_valid,
  output logic                pay_ready,
  input  logic [63:0]         pay_data,
  output logic                blk_valid,
  input  logic                blk_ready,
  output logic [ADDR_W-1:0]   blk_addr,
  output logic [BLK_BITS-1:0] blk_data,
  output logic                wb_req,
  input  logic                wb_ack,
  output logic [LEN_W-1:0]    wb_len,
  output logic                irq
);
  localparam int CNT_W  = LEN_W;
  localparam int SLOT_W = $clog2(SLOTS + 1);

  seg_state_e state_q;
  logic [CH_W-1:0]       chan_q;
  logic [LEN_W-1:0]      len_q;
  logic [SLOTS-1:0][63:0] buf_q;
  logic [SLOT_W-1:0]     slot_q;
  logic [CNT_W-1:0]      words_left_q, blk_idx_q, nblk_q;
  logic [5:0]            last_vcnt;

  // named events for the checker
  logic pkt_fire, pay_fire, blk_fire, wb_done, is_last;
  logic [1:0] pos_code;
  logic [BLK_BITS-1:0] raw_blk;

  assign pkt_ready = (state_q == S_IDLE);
  assign pay_ready = (state_q == S_FILL) && (slot_q != SLOT_W'(SLOTS)) && (words_left_q != '0);
  assign blk_valid = (state_q == S_SEND);
  assign wb_req    = (state_q == S_WB);
  assign irq       = (state_q == S_IRQ);
  assign wb_len    = len_q;

  assign pkt_fire = pkt_valid && pkt_ready;
  assign pay_fire = pay_valid && pay_ready;
  assign blk_fire = blk_valid && blk_ready;
  assign wb_done  = wb_req && wb_ack;
  assign is_last  = (blk_idx_q == nblk_q - CNT_W'(1));

  always_comb begin
    if (is_last)               pos_code = POS_EOP;
    else if (blk_idx_q == '0)  pos_code = POS_SOP;
    else                       pos_code = POS_MOP;
  end

  assign raw_blk = buf_q;

  seg_addr #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_addr (
    .base(cfg_base), .chan(chan_q), .pos(pos_code),
    .vfield(last_vcnt[4:0]), .addr(blk_addr)
  );

  seg_mask u_mask (
    .trim(is_last), .keep(last_vcnt), .din(raw_blk), .dout(blk_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      chan_q       <= '0;
      len_q        <= '0;
      buf_q        <= '0;
      slot_q       <= '0;
      words_left_q <= '0;
      blk_idx_q    <= '0;
      nblk_q       <= '0;
      last_vcnt    <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (pkt_fire) begin
          chan_q       <= pkt_chan;
          len_q        <= pkt_len;
          buf_q        <= '0;
          buf_q[0]     <= pkt_dscr;
          slot_q       <= SLOT_W'(1);
          words_left_q <= CNT_W'(words_for(32'(pkt_len)));
          nblk_q       <= CNT_W'(blocks_for(32'(pkt_len)));
          last_vcnt    <= 6'(last_valid(32'(pkt_len)));
          blk_idx_q    <= '0;
          state_q      <= S_FILL;
        end
        S_FILL: begin
          if (pay_fire) begin
            buf_q[slot_q[1:0]] <= pay_data;
            slot_q             <= slot_q + SLOT_W'(1);
            words_left_q       <= words_left_q - CNT_W'(1);
          end else if (!pay_ready) begin
            state_q <= S_SEND;
          end
        end
        S_SEND: if (blk_fire) begin
          if (is_last) begin
            state_q <= S_WB;
          end else begin
            blk_idx_q <= blk_idx_q + CNT_W'(1);
            buf_q     <= '0;
            slot_q    <= '0;
            state_q   <= S_FILL;
          end
        end
        S_WB:  if (wb_done) state_q <= S_IRQ;
        S_IRQ: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_checker.sv
module seg_checker import seg_pkg::*; #(
  parameter int ADDR_W = 40
) (
  input logic                clk,
  input logic                rst_n,
  input logic                blk_valid,
  input logic                blk_ready,
  input logic [ADDR_W-1:0]   blk_addr,
  input logic [BLK_BITS-1:0] blk_data,
  input logic                pay_ready,
  input logic                pkt_ready,
  input logic                wb_req,
  input logic                wb_ack,
  input logic                irq,
  input logic [1:0]          pos_code,
  input logic                is_last,
  input logic [5:0]          last_vcnt
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && !blk_ready |=> blk_valid && $stable(blk_addr) && $stable(blk_data));

  assert_no_code3_R4: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> pos_code != 2'd3);

  assert_last_eop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && is_last |-> pos_code == POS_EOP);

  assert_tail_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && is_last && (last_vcnt < 6'd32) |-> (blk_data >> {last_vcnt, 3'b000}) == '0);

  assert_wb_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> !blk_valid && !pay_ready);

  assert_irq_after_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(wb_req && wb_ack));

  assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_idle_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pkt_ready, blk_valid, wb_req, irq}));
endmodule

bind pkt_blk_segmenter seg_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_ready(blk_ready),
  .blk_addr(blk_addr), .blk_data(blk_data), .pay_ready(pay_ready),
  .pkt_ready(pkt_ready), .wb_req(wb_req), .wb_ack(wb_ack), .irq(irq),
  .pos_code(pos_code), .is_last(is_last), .last_vcnt(last_vcnt)
);

// File: tb/sim_pkt_blk_segmenter.sv
module sim_pkt_blk_segmenter;
  localparam int ADDR_W = 40;
  localparam int CH_W   = 2;
  localparam int LEN_W  = 7;
  localparam logic [ADDR_W-1:0] BASE = 40'h34_0000_0000;

  logic clk = 0, rst_n = 0;
  logic [ADDR_W-1:0] cfg_base = BASE;
  logic pkt_valid = 0, pay_valid = 0, blk_ready = 0, wb_ack = 0;
  logic pkt_ready, pay_ready, blk_valid, wb_req, irq;
  logic [CH_W-1:0] pkt_chan = '0;
  logic [LEN_W-1:0] pkt_len = '0, wb_len;
  logic [63:0] pkt_dscr = '0, pay_data = '0;
  logic [ADDR_W-1:0] blk_addr;
  logic [255:0] blk_data;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pkt_blk_segmenter #(.ADDR_W(ADDR_W), .CH_W(CH_W), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_chan(pkt_chan),
    .pkt_len(pkt_len), .pkt_dscr(pkt_dscr),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
    .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_addr(blk_addr),
    .blk_data(blk_data), .wb_req(wb_req), .wb_ack(wb_ack), .wb_len(wb_len),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pbyte(input int pk, input int k);
    return 8'(k * 29 + pk * 11 + 3);
  endfunction

  function automatic logic [63:0] dscr_of(input int pk);
    return 64'(pk + 1) * 64'h9E37_79B9_7F4A_7C15;
  endfunction

  // expected block content: descriptor bytes, then payload, then zeros
  function automatic logic [255:0] exp_blk(input int pk, input int len, input int bi);
    logic [255:0] v = '0;
    logic [63:0] d = dscr_of(pk);
    for (int b = 0; b < 32; b++) begin
      int s = 32 * bi + b;
      if (s < 8)            v[8*b +: 8] = d[8*s +: 8];
      else if (s < 8 + len) v[8*b +: 8] = pbyte(pk, s - 8);
    end
    return v;
  endfunction

  function automatic logic [ADDR_W-1:0] exp_addr(input int ch, input int len, input int bi);
    int nb = (len + 8 + 31) / 32;
    int pos = (bi == nb - 1) ? 2 : (bi == 0 ? 0 : 1);
    int v = (len + 8 - 32 * (nb - 1)) % 32;
    logic [ADDR_W-1:0] a = BASE + (ADDR_W'(ch) << 18) + (ADDR_W'(pos) << 16);
    if (pos == 2) a = a + (ADDR_W'(v) << 11);
    return a;
  endfunction

  task automatic feed(input int pk, input int len);
    int nw = (len + 7) / 8;
    for (int j = 0; j < nw; j++) begin
      logic [63:0] w;
      for (int b = 0; b < 8; b++)
        w[8*b +: 8] = (8*j + b < len) ? pbyte(pk, 8*j + b) : 8'hA5;
      if ((len % 2) == 1 && j == 1) begin
        @(negedge clk); pay_valid = 0;
      end
      @(negedge clk); pay_valid = 1; pay_data = w; #1;
      while (!pay_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk); pay_valid = 0;
  endtask

  task automatic watch(input int pk, input int ch, input int len);
    int nb = (len + 8 + 31) / 32;
    int i = 0;
    while (i < nb) begin
      @(negedge clk);
      blk_ready = ((cyc + len) % 3 != 0) || (len % 4 == 0);
      #1;
      if (blk_valid && blk_ready) begin
        chk($sformatf("R3/R4/R5/R6 addr pkt%0d blk%0d", pk, i), 256'(blk_addr), 256'(exp_addr(ch, len, i)));
        chk($sformatf("R1/R2/R7 data pkt%0d blk%0d", pk, i), blk_data, exp_blk(pk, len, i));
        i++;
      end
    end
    @(negedge clk); blk_ready = 0; #1;
    chk($sformatf("R1 no extra block pkt%0d", pk), 256'(blk_valid), 256'(0));
  endtask

  task automatic run_pkt(input int pk, input int ch, input int len);
    @(negedge clk);
    pkt_valid = 1; pkt_chan = CH_W'(ch); pkt_len = LEN_W'(len); pkt_dscr = dscr_of(pk);
    #1; chk("R11 ready when idle", 256'(pkt_ready), 256'(1));
    @(negedge clk);
    if (len % 5 == 0) begin
      // rival start request held during the packet must be ignored (R11)
      pkt_len = LEN_W'(len + 37); pkt_chan = CH_W'(ch + 1); pkt_dscr = ~pkt_dscr;
    end else pkt_valid = 0;
    #1; chk("R11 busy after start", 256'(pkt_ready), 256'(0));
    fork
      feed(pk, len);
      watch(pk, ch, len);
    join
    #1;
    while (!wb_req) begin @(negedge clk); #1; end
    pkt_valid = 0;
    chk("R9 wb length", 256'(wb_len), 256'(len));
    chk("R11 not ready in writeback", 256'(pkt_ready), 256'(0));
    for (int k = 0; k < (len % 3); k++) begin
      @(negedge clk); #1;
      chk("R10 no irq before ack", 256'(irq), 256'(0));
      chk("R9 wb held", 256'(wb_req), 256'(1));
    end
    @(negedge clk); wb_ack = 1;
    @(negedge clk); wb_ack = 0; #1;
    chk("R10 irq after ack", 256'(irq), 256'(1));
    @(negedge clk); #1;
    chk("R10 irq single pulse", 256'(irq), 256'(0));
    chk("R11 idle after irq", 256'(pkt_ready), 256'(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R12 reset pkt_ready", 256'(pkt_ready), 256'(1));
    chk("R12 reset outputs", 256'({blk_valid, pay_ready, wb_req, irq}), 256'(0));
    rst_n = 1;
    // full sweep of every legal length, channel cycling
    for (int len = 1; len < 128; len++) run_pkt(len, len % 4, len);
    // boundary lengths again on other channels: exact fit, one over, two exact blocks
    run_pkt(200, 3, 24);
    run_pkt(201, 2, 25);
    run_pkt(202, 1, 56);
    run_pkt(203, 0, 120);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule